// File: doc/BRIEF.md
# Triggered Probe Capture Buffer

This block is an embedded logic analyser. It watches a small vector of one-bit probes and a 32-bit probe word. After an explicit arm command it waits for a trigger condition. Once the condition is met it writes one sample per clock into an on-chip buffer, from address 0 upward, until the buffer is full. It then raises a completion flag and stops writing. Each sample holds both the bit probes and the word probe.

Three trigger kinds are chosen when the block is armed:
- a transition on one selected probe bit, from a configured previous value to a configured new value;
- an exact match of the probe word against a configured pattern;
- a periodic monitor that needs no condition. It captures at once, then captures again each time a programmed number of idle cycles has passed after the previous capture ended.

The readout is a random-access port: an address goes in and the stored sample comes out one cycle later. Capture never stalls, so the block has no valid/ready handshake and no back-pressure. The read port has no effect on capture, and the probes are sampled unconditionally on every clock.

Top module: `probe_capture`

## Requirements
- R1: After reset, `triggered` and `done` are 0, and nothing is written to the buffer until `arm` has been pulsed.
- R2: Trigger conditions that occur before the first `arm` are ignored: `triggered` and `done` stay 0.
- R3: With mode 2'b00 (edge), the trigger fires in the first cycle after arming in which `probe_bits[edge_sel]` had the value `edge_old` in the previous cycle and has the value `edge_new` in the current cycle. Equal old and new values act as a level condition.
- R4: With mode 2'b01 (match), the trigger fires in the first cycle after arming in which `probe_word` equals `match_pat`.
- R5: The sample taken in the trigger cycle is stored at address 0, and the samples of the following cycles go to consecutive addresses until DEPTH samples are stored. A sample is `{probe_bits, probe_word}`, with `probe_word` in the low 32 bits.
- R6: `triggered` rises the cycle after the trigger and `done` rises the cycle after the last sample. Outside the periodic mode both flags then hold, and no further writes happen until the next `arm`.
- R7: An `arm` pulse at any time clears both flags, abandons any capture or gap in progress, and latches `mode`. It takes priority over a trigger or a periodic restart that falls in the same cycle.
- R8: With mode 2'b10 or 2'b11 (periodic), a capture starts in the first cycle after arming. Each later capture begins after exactly `period` idle cycles. `done` is high for `period`+1 cycles between captures and low for DEPTH-1 cycles during each capture after the first.
- R9: `rd_data` shows the sample stored at `rd_addr` one clock after the address is presented, at any address and in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle command that starts a new wait for a trigger |
| mode | input | 2 | Trigger kind, latched at arm: 00 edge, 01 match, 1x periodic |
| edge_sel | input | $clog2(NBITS) | Index of the probe bit used by the edge trigger |
| edge_old | input | 1 | Required value of the selected bit in the previous cycle |
| edge_new | input | 1 | Required value of the selected bit in the current cycle |
| match_pat | input | WORD_W | Pattern compared with the probe word |
| period | input | CNT_W | Idle cycles between periodic captures |
| probe_bits | input | NBITS | One-bit probes |
| probe_word | input | WORD_W | Word probe |
| rd_addr | input | $clog2(DEPTH) | Readout address |
| rd_data | output | NBITS+WORD_W | Sample at the previous cycle's readout address |
| triggered | output | 1 | A capture has started since the last arm |
| done | output | 1 | The latest capture has filled the buffer |

## Verification
Two functions can collide in one cycle: an `arm` pulse can land in the same cycle as a live trigger condition or as a periodic restart. The bench provokes the first case in the middle of a match capture, with the pattern set to the current probe word, and the second case at the moment the periodic gap expires (a gap of zero cycles). It judges the result by the flags, which must be cleared, and by the later buffer contents, which must start at the new trigger or be left whole from the last periodic capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_ARMED  = 2'd1,
    S_FILL   = 2'd2,
    S_GAP    = 2'd3
  } cap_state_e;

  localparam logic [1:0] MODE_EDGE  = 2'b00;
  localparam logic [1:0] MODE_MATCH = 2'b01;
  localparam logic [1:0] MODE_FREE  = 2'b10;
endpackage

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int NBITS  = 8,
  parameter int WORD_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBITS-1:0]  probe_bits,
  input  logic [WORD_W-1:0] probe_word,
  input  logic [SEL_W-1:0]  edge_sel,
  input  logic              edge_old,
  input  logic              edge_new,
  input  logic [WORD_W-1:0] match_pat,
  output logic              edge_hit,
  output logic              match_hit
);
  logic [NBITS-1:0] last_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_bits <= '0;
    else        last_bits <= probe_bits;
  end

  always_comb begin
    edge_hit  = (last_bits[edge_sel] == edge_old) && (probe_bits[edge_sel] == edge_new);
    match_hit = (probe_word == match_pat);
  end
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic             edge_hit,
  input  logic             match_hit,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             triggered,
  output logic             done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e       st;
  logic [1:0]       mode_q;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] gap;
  logic             fire_now;
  logic             restart;

  always_comb begin
    fire_now = 1'b0;
    if (st == S_ARMED) begin
      if (mode_q[1])      fire_now = 1'b1;
      else if (mode_q[0]) fire_now = match_hit;
      else                fire_now = edge_hit;
    end
    restart = (st == S_GAP) && (gap >= period);
    wr_en   = !arm && (fire_now || restart || (st == S_FILL));
    wr_addr = (st == S_FILL) ? ptr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      mode_q    <= MODE_EDGE;
      ptr       <= '0;
      gap       <= '0;
      triggered <= 1'b0;
      done      <= 1'b0;
    end else if (arm) begin
      st        <= S_ARMED;
      mode_q    <= mode;
      ptr       <= '0;
      gap       <= '0;
      triggered <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (st)
        S_ARMED: begin
          if (fire_now) begin
            st        <= S_FILL;
            ptr       <= AW'(1);
            triggered <= 1'b1;
          end
        end
        S_FILL: begin
          if (ptr == LAST) begin
            done <= 1'b1;
            gap  <= '0;
            st   <= mode_q[1] ? S_GAP : S_IDLE;
          end else begin
            ptr <= ptr + AW'(1);
          end
        end
        S_GAP: begin
          if (restart) begin
            st   <= S_FILL;
            ptr  <= AW'(1);
            done <= 1'b0;
          end else begin
            gap <= gap + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q[1]) |-> !wr_en);

  // R7
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!triggered && !done));

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != LAST) |=> (arm || (wr_en && wr_addr == $past(wr_addr) + AW'(1))));

  // R6
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST) |=> done);

  // R5
  trig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> ($past(wr_en) && $past(wr_addr) == '0));
endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 40,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/probe_capture.sv
module probe_capture #(
  parameter int NBITS  = 8,
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024,
  parameter int CNT_W  = 16,
  localparam int SEL_W = $clog2(NBITS),
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = NBITS + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  edge_sel,
  input  logic              edge_old,
  input  logic              edge_new,
  input  logic [WORD_W-1:0] match_pat,
  input  logic [CNT_W-1:0]  period,
  input  logic [NBITS-1:0]  probe_bits,
  input  logic [WORD_W-1:0] probe_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [SW-1:0]     rd_data,
  output logic              triggered,
  output logic              done
);
  logic          edge_hit;
  logic          match_hit;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] sample;

  assign sample = {probe_bits, probe_word};

  trig_detect #(.NBITS(NBITS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_bits (probe_bits),
    .probe_word (probe_word),
    .edge_sel   (edge_sel),
    .edge_old   (edge_old),
    .edge_new   (edge_new),
    .match_pat  (match_pat),
    .edge_hit   (edge_hit),
    .match_hit  (match_hit)
  );

  capture_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode      (mode),
    .period    (period),
    .edge_hit  (edge_hit),
    .match_hit (match_hit),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .triggered (triggered),
    .done      (done)
  );

  sample_ram #(.DEPTH(DEPTH), .W(SW), .AW(AW)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (sample),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R1
  no_early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!triggered) |-> !done);
endmodule

// File: tb/test_probe_capture.sv
`timescale 1ns/1ps
module test_probe_capture;
  localparam int NB = 4;
  localparam int WW = 32;
  localparam int DP = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [1:0]    edge_sel = '0;
  logic          edge_old = 1'b0;
  logic          edge_new = 1'b1;
  logic [WW-1:0] match_pat = '0;
  logic [CW-1:0] period = '0;
  logic [NB-1:0] probe_bits = '0;
  logic [WW-1:0] probe_word;
  logic [3:0]    rd_addr = '0;
  logic [NB+WW-1:0] rd_data;
  logic          triggered;
  logic          done;

  logic [WW-1:0] cyc = '0;
  logic [WW-1:0] ofs = '0;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 32'd1;
  assign probe_word = cyc + ofs;

  probe_capture #(.NBITS(NB), .WORD_W(WW), .DEPTH(DP), .CNT_W(CW)) i_probe_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .edge_sel(edge_sel),
    .edge_old(edge_old), .edge_new(edge_new), .match_pat(match_pat), .period(period),
    .probe_bits(probe_bits), .probe_word(probe_word), .rd_addr(rd_addr),
    .rd_data(rd_data), .triggered(triggered), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_arm(input logic [1:0] m);
    mode = m;
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 500) begin tick(); n++; end
    check(done == 1'b1, req, {63'd0, done}, 64'd1);
  endtask

  task automatic read_at(input int a, output logic [NB+WW-1:0] d);
    rd_addr = 4'(a);
    tick();
    tick();
    d = rd_data;
  endtask

  task automatic check_run(input logic [WW-1:0] w0, input string req);
    logic [NB+WW-1:0] d;
    for (int i = 0; i < DP; i++) begin
      read_at(i, d);
      check(d[WW-1:0] == w0 + WW'(i), req, 64'(d[WW-1:0]), 64'(w0 + WW'(i)));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NB+WW-1:0] d;
    logic [WW-1:0] w;
    logic [WW-1:0] pats [4];
    int hi, lo;
    pats[0] = 32'h0000_00FF; pats[1] = 32'hFFFF_FFF8;
    pats[2] = 32'h1234_5678; pats[3] = 32'h8000_0000;

    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(triggered == 1'b0, "R1 triggered", {63'd0, triggered}, 0);
    check(done == 1'b0, "R1 done", {63'd0, done}, 0);

    // R2 conditions before any arm are ignored
    mode = 2'b01;
    match_pat = probe_word + 32'd1;
    edge_sel = 2'd0; edge_old = 1'b0; edge_new = 1'b1;
    probe_bits = 4'b0000;
    tick();
    probe_bits = 4'b0001;
    repeat (4) tick();
    check(triggered == 1'b0, "R2 triggered", {63'd0, triggered}, 0);
    check(done == 1'b0, "R2 done", {63'd0, done}, 0);

    // R3 edge sweep over every bit and every old/new pair
    for (int s = 0; s < NB; s++) begin
      for (int o = 0; o < 2; o++) begin
        for (int n = 0; n < 2; n++) begin
          edge_sel = 2'(s); edge_old = o[0]; edge_new = n[0];
          probe_bits = {NB{~o[0]}};
          probe_bits[s] = o[0];
          tick();
          do_arm(2'b00);
          check(triggered == 1'b0, "R7 arm clears triggered", {63'd0, triggered}, 0);
          if (o == n) begin
            w = probe_word;
          end else begin
            tick();
            check(triggered == 1'b0, "R3 no fire before edge", {63'd0, triggered}, 0);
            probe_bits[s] = n[0];
            w = probe_word;
          end
          tick();
          check(triggered == 1'b1, "R6 triggered after edge", {63'd0, triggered}, 1);
          wait_done("R3 edge capture done");
          repeat (10) tick();
          check(done && triggered, "R6 flags hold", {62'd0, done, triggered}, 3);
          read_at(0, d);
          check(d[WW+s] == n[0], "R5 bit sample at addr 0", {63'd0, d[WW+s]}, {63'd0, n[0]});
          check_run(w, "R3 R5 edge buffer");
        end
      end
    end

    // R4 match sweep, including a word wrap inside the capture
    for (int k = 0; k < 4; k++) begin
      match_pat = 32'h0;
      ofs = 32'h4000_0000;
      do_arm(2'b01);
      match_pat = pats[k];
      ofs = pats[k] - cyc - 32'd3;
      tick(); tick();
      check(triggered == 1'b0, "R4 no fire before match", {63'd0, triggered}, 0);
      wait_done("R4 match capture done");
      check_run(pats[k], "R4 R5 match buffer");
    end

    // R7 arm in the same cycle as a live match condition
    match_pat = 32'h0;
    ofs = 32'h5000_0000;
    do_arm(2'b01);
    match_pat = probe_word + 32'd2;
    repeat (6) tick();
    check(triggered == 1'b1, "R4 capture running", {63'd0, triggered}, 1);
    match_pat = probe_word;
    arm = 1'b1;
    tick();
    arm = 1'b0;
    check(triggered == 1'b0, "R7 arm wins over match", {63'd0, triggered}, 0);
    tick();
    check(triggered == 1'b0, "R7 stale condition no fire", {63'd0, triggered}, 0);
    match_pat = probe_word + 32'd3;
    w = probe_word + 32'd3;
    wait_done("R7 recapture done");
    check_run(w, "R7 buffer starts at new trigger");

    // R8 periodic gaps, stopped by an arm at the gap boundary
    for (int p = 0; p < 4; p++) begin
      period = CW'(p * 2);
      do_arm(2'b10);
      check(triggered == 1'b0, "R8 arm clears", {63'd0, triggered}, 0);
      wait_done("R8 first capture done");
      hi = 0;
      while (done && hi < 100) begin hi++; tick(); end
      check(hi == p * 2 + 1, "R8 done high span", 64'(hi), 64'(p * 2 + 1));
      lo = 0;
      while (!done && lo < 100) begin lo++; tick(); end
      check(lo == DP - 1, "R8 done low span", 64'(lo), 64'(DP - 1));
      edge_sel = 2'd0; edge_old = 1'b0; edge_new = 1'b1;
      probe_bits = 4'b0000;
      do_arm(2'b00);
      check(done == 1'b0, "R7 arm clears done", {63'd0, done}, 0);
      read_at(0, d);
      w = d[WW-1:0];
      check_run(w, "R8 R9 periodic buffer intact");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule